// File: doc/BRIEF.md
# Byte-Level I2C Status/Control Register with Bus Stall

This block holds the 8-bit status and control word that firmware uses to steer an I2C engine one byte at a time. The serial shifter reports events to it: a finished byte with its acknowledge slot, whether that byte was an address, the ninth bit sampled on the bus, Start and Stop detection, lost arbitration and a misplaced Start or Stop. From these events the block keeps status bits that hardware sets, and control bits that firmware writes.

After every finished byte the block raises its interrupt and asks the bus driver to hold SCL low once the clock is next seen low. The hold lasts until the CPU writes the register. Reads have no side effect. Each status bit follows its own clearing rule. Some clear when firmware writes a 0, some also clear on a detected Start, and Bus Error and Stop Status are never cleared by hardware.

Top module: `i2cbs_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00, the interrupt is low and SCL is not held. Bit order from 7 down to 0: bus error, lost arbitration, stop seen, ack out, address, transmit, last received bit, byte complete.
- R2: Writing 0 to a status bit (7, 6, 5, 3, 1, 0) clears it. Writing 1 leaves it unchanged. A hardware set in the same cycle overrides the clear.
- R3: A write loads transmit (bit 2) and ack out (bit 4) from the written data. A hardware clear in the same cycle overrides the write. Bits 2 and 4 also appear on the tx_mode and ack_out outputs.
- R4: A finished byte sets byte complete (bit 0). It also sets address (bit 3) when the byte was flagged as an address.
- R5: On a finished byte with transmit = 1, bit 1 takes the sampled ninth bit (0 = ACKed, 1 = NAKed). In receive mode bit 1 is left unchanged.
- R6: A finished byte clears ack out (bit 4).
- R7: A detected Start clears bits 0, 1, 2 and 6. It leaves bits 3, 4, 5 and 7 unchanged.
- R8: Lost arbitration sets bit 6 in the cycle after the event and raises no interrupt by itself.
- R9: A detected Stop sets bit 5. Only a firmware write of 0 clears it.
- R10: A misplaced Start/Stop sets bit 7. Hardware never clears it; a Start does not clear it either.
- R11: The interrupt is the level OR of byte complete and bus error.
- R12: After a finished byte, SCL hold rises one cycle after the first edge at which SCL is sampled low. It stays high through reads and falls after a write. A write in the same cycle as a finished byte does not release the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (no side effect) |
| cpu_wdata | input | 8 | Write data |
| ev_byte_done | input | 1 | Byte plus acknowledge slot finished |
| ev_addr | input | 1 | Finished byte was an address |
| ev_ninth | input | 1 | Ninth bit sampled on the bus |
| ev_start | input | 1 | Start detected |
| ev_stop | input | 1 | Stop detected |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_misplaced | input | 1 | Start or Stop at an illegal point |
| scl_is_low | input | 1 | SCL currently low |
| reg_rdata | output | 8 | Register value |
| irq | output | 1 | Interrupt level |
| scl_hold | output | 1 | Request to stretch SCL low |
| tx_mode | output | 1 | Transmit direction to the shifter |
| ack_out | output | 1 | Acknowledge value to send |

## Verification
The bench runs a transmitted byte NAKed by the receiver and a received address byte. The pair shows that the ninth bit is captured only in transmit mode, and that ack out is cleared while address is set. A Start issued with every bit set separates the bits that clear on Start from those that only firmware clears. Writes that land in the same cycle as hardware events show which source wins for status bits, for control bits and for stall release. SCL is held high for a few cycles after a byte, with reads in between, to show that the hold waits for a low clock and that reads never release it.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;
   localparam int REG_W   = 8;
   localparam int B_BC    = 0;
   localparam int B_LRB   = 1;
   localparam int B_TX    = 2;
   localparam int B_ADR   = 3;
   localparam int B_ACK   = 4;
   localparam int B_STOP  = 5;
   localparam int B_ARB   = 6;
   localparam int B_BERR  = 7;
   localparam logic [REG_W-1:0] STAT_MASK  = 8'hEB;
   localparam logic [REG_W-1:0] START_CLR  = 8'h43;
endpackage

// File: rtl/i2cbs_status.sv
module i2cbs_status
   import i2cbs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             tx_q,
   input  logic             byte_done,
   input  logic             is_addr,
   input  logic             ninth,
   input  logic             start,
   input  logic             stop,
   input  logic             arb_lost,
   input  logic             misplaced,
   output logic [REG_W-1:0] stat_q
);
   logic [REG_W-1:0] set_v, wclr_v, sclr_v, ld_v, ldval_v;

   always_comb begin
      set_v          = '0;
      set_v[B_BC]    = byte_done;
      set_v[B_ADR]   = byte_done & is_addr;
      set_v[B_STOP]  = stop;
      set_v[B_ARB]   = arb_lost;
      set_v[B_BERR]  = misplaced;
      wclr_v         = wr ? (~wdata & STAT_MASK) : '0;
      sclr_v         = start ? START_CLR : '0;
      ld_v           = '0;
      ldval_v        = '0;
      ld_v[B_LRB]    = byte_done & tx_q;
      ldval_v[B_LRB] = ninth;
   end

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (STAT_MASK[i]) begin : g_stat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stat_q[i] <= 1'b0;
            else if (ld_v[i]) stat_q[i] <= ldval_v[i];
            else              stat_q[i] <= (stat_q[i] & ~(wclr_v[i] | sclr_v[i])) | set_v[i];
         end
      end else begin : g_none
         assign stat_q[i] = 1'b0;
      end
   end

   assert_bc_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> stat_q[B_BC]);
   assert_addr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && is_addr) |=> stat_q[B_ADR]);
   assert_lrb_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && tx_q) |=> (stat_q[B_LRB] == $past(ninth)));
   assert_start_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !byte_done && !arb_lost) |=> (!stat_q[B_BC] && !stat_q[B_LRB] && !stat_q[B_ARB]));
   assert_arb_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> stat_q[B_ARB]);
   assert_stop_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> stat_q[B_STOP]);
   assert_berr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[B_BERR] && !(wr && !wdata[B_BERR])) |=> stat_q[B_BERR]);
   assert_w1_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[B_STOP] && stat_q[B_STOP]) |=> stat_q[B_STOP]);
endmodule

// File: rtl/i2cbs_ctrl_bits.sv
module i2cbs_ctrl_bits
   import i2cbs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             byte_done,
   input  logic             start,
   output logic             tx_q,
   output logic             ack_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         if (start)    tx_q <= 1'b0;
         else if (wr)  tx_q <= wdata[B_TX];
         if (byte_done) ack_q <= 1'b0;
         else if (wr)   ack_q <= wdata[B_ACK];
      end
   end

   assert_ack_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !ack_q);
   assert_tx_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !tx_q);
   assert_tx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !start) |=> (tx_q == $past(wdata[B_TX])));
endmodule

// File: rtl/i2cbs_stall.sv
module i2cbs_stall #(
   parameter bit HOLD_WAIT_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic rd,
   input  logic byte_done,
   input  logic scl_low,
   output logic hold_q
);
   logic release_now;
   assign release_now = wr & ~byte_done;

   if (HOLD_WAIT_LOW) begin : g_wait_low
      logic armed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b0;
            hold_q  <= 1'b0;
         end else begin
            if (byte_done) armed_q <= 1'b1;
            else if (wr)   armed_q <= 1'b0;
            hold_q <= release_now ? 1'b0 : (hold_q | (armed_q & scl_low));
         end
      end
      assert_hold_needs_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (!hold_q && !scl_low) |=> !hold_q);
   end else begin : g_immediate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold_q <= 1'b0;
         else        hold_q <= release_now ? 1'b0 : (hold_q | byte_done);
      end
   end

   assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
      release_now |=> !hold_q);
   assert_read_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr && hold_q) |=> hold_q);
endmodule

// File: rtl/i2cbs_ctrl_reg.sv
module i2cbs_ctrl_reg
   import i2cbs_pkg::*;
#(
   parameter int CPU_W         = 8,
   parameter bit IRQ_ON_BUSERR = 1'b1,
   parameter bit HOLD_WAIT_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_wr,
   input  logic             cpu_rd,
   input  logic [CPU_W-1:0] cpu_wdata,
   input  logic             ev_byte_done,
   input  logic             ev_addr,
   input  logic             ev_ninth,
   input  logic             ev_start,
   input  logic             ev_stop,
   input  logic             ev_arb_lost,
   input  logic             ev_misplaced,
   input  logic             scl_is_low,
   output logic [CPU_W-1:0] reg_rdata,
   output logic             irq,
   output logic             scl_hold,
   output logic             tx_mode,
   output logic             ack_out
);
   if (CPU_W != REG_W) begin : g_bad_width
      $error("i2cbs_ctrl_reg: CPU_W must equal %0d", REG_W);
   end

   logic [REG_W-1:0] stat_w;
   logic             tx_w, ack_w;

   i2cbs_status u_status (
      .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .wdata(cpu_wdata), .tx_q(tx_w),
      .byte_done(ev_byte_done), .is_addr(ev_addr), .ninth(ev_ninth),
      .start(ev_start), .stop(ev_stop), .arb_lost(ev_arb_lost),
      .misplaced(ev_misplaced), .stat_q(stat_w)
   );

   i2cbs_ctrl_bits u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .wdata(cpu_wdata),
      .byte_done(ev_byte_done), .start(ev_start), .tx_q(tx_w), .ack_q(ack_w)
   );

   i2cbs_stall #(.HOLD_WAIT_LOW(HOLD_WAIT_LOW)) u_stall (
      .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .rd(cpu_rd),
      .byte_done(ev_byte_done), .scl_low(scl_is_low), .hold_q(scl_hold)
   );

   always_comb begin
      reg_rdata        = stat_w;
      reg_rdata[B_TX]  = tx_w;
      reg_rdata[B_ACK] = ack_w;
   end

   if (IRQ_ON_BUSERR) begin : g_irq_be
      assign irq = stat_w[B_BC] | stat_w[B_BERR];
   end else begin : g_irq_bc
      assign irq = stat_w[B_BC];
   end

   assign tx_mode = tx_w;
   assign ack_out = ack_w;

   assert_arb_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && ev_arb_lost && !ev_byte_done && !ev_misplaced) |=> !irq);
   assert_irq_follows_bc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte_done |=> irq);
   assert_stop_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[B_STOP] && !cpu_wr) |=> reg_rdata[B_STOP]);
endmodule

// File: tb/i2cbs_ctrl_reg_tb.sv
module i2cbs_ctrl_reg_tb_top;
   typedef struct {
      string      tag;
      logic [7:0] r;
      logic       irq;
      logic       hold;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_wr = 0, cpu_rd = 0;
   logic [7:0] cpu_wdata = 0;
   logic ev_byte_done = 0, ev_addr = 0, ev_ninth = 0, ev_start = 0;
   logic ev_stop = 0, ev_arb_lost = 0, ev_misplaced = 0, scl_is_low = 0;
   logic [7:0] reg_rdata;
   logic irq, scl_hold, tx_mode, ack_out;

   int total = 0, bad = 0;
   exp_t q[$];
   logic [7:0] m_r = 0;
   logic m_arm = 0, m_hold = 0;
   bit done = 0;

   always #10 clk = ~clk;

   i2cbs_ctrl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .ev_byte_done(ev_byte_done), .ev_addr(ev_addr),
      .ev_ninth(ev_ninth), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_arb_lost(ev_arb_lost), .ev_misplaced(ev_misplaced),
      .scl_is_low(scl_is_low), .reg_rdata(reg_rdata), .irq(irq),
      .scl_hold(scl_hold), .tx_mode(tx_mode), .ack_out(ack_out)
   );

   // model built from the requirement list
   task automatic model();
      logic [7:0] n, wc, sc, st;
      wc = cpu_wr ? (~cpu_wdata & 8'hEB) : 8'h00;
      sc = ev_start ? 8'h43 : 8'h00;
      st = {ev_misplaced, ev_arb_lost, ev_stop, 1'b0, ev_byte_done & ev_addr, 2'b00, ev_byte_done};
      n = ((m_r & 8'hEB) & ~(wc | sc)) | st;
      if (ev_byte_done && m_r[2]) n[1] = ev_ninth;
      n[2] = ev_start ? 1'b0 : (cpu_wr ? cpu_wdata[2] : m_r[2]);
      n[4] = ev_byte_done ? 1'b0 : (cpu_wr ? cpu_wdata[4] : m_r[4]);
      m_hold = (cpu_wr && !ev_byte_done) ? 1'b0 : (m_hold | (m_arm & scl_is_low));
      m_arm = ev_byte_done ? 1'b1 : (cpu_wr ? 1'b0 : m_arm);
      m_r = n;
   endtask

   task automatic step(string tag, logic wr, logic [7:0] wd, logic rd, logic bd,
                       logic ad, logic nb, logic st, logic sp, logic al,
                       logic me, logic scl);
      exp_t e;
      @(negedge clk);
      cpu_wr = wr; cpu_wdata = wd; cpu_rd = rd; ev_byte_done = bd; ev_addr = ad;
      ev_ninth = nb; ev_start = st; ev_stop = sp; ev_arb_lost = al;
      ev_misplaced = me; scl_is_low = scl;
      @(posedge clk);
      model();
      #1;
      e.tag = tag; e.r = m_r; e.irq = m_r[0] | m_r[7]; e.hold = m_hold;
      q.push_back(e);
   endtask

   task automatic idle(string tag, logic scl);
      step(tag, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, scl);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         wait (q.size() > 0);
         e = q.pop_front();
         total++;
         if (reg_rdata !== e.r || irq !== e.irq || scl_hold !== e.hold ||
             tx_mode !== e.r[2] || ack_out !== e.r[4]) begin
            bad++;
            $display("FAIL %s: got reg=%h irq=%b hold=%b tx=%b ack=%b exp reg=%h irq=%b hold=%b",
                     e.tag, reg_rdata, irq, scl_hold, tx_mode, ack_out, e.r, e.irq, e.hold);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1;
      begin
         exp_t e;
         e.tag = "R1 reset"; e.r = 8'h00; e.irq = 0; e.hold = 0;
         q.push_back(e);
      end
      @(negedge clk) rst_n = 1'b1;
      idle("R1 idle", 1);
      // transmit byte, NAKed (R3, R4, R5, R11, R12)
      step("R3 write tx", 1, 8'h04, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R5 tx byte nak", 0, 8'h00, 0, 1, 0, 1, 0, 0, 0, 0, 0);
      idle("R12 scl high no hold", 0);
      step("R12 read no release", 0, 8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 0);
      idle("R12 scl low arm", 1);
      step("R12 held through read", 0, 8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 1);
      step("R2 write0 bc releases", 1, 8'hFE, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      idle("R12 stays released", 1);
      // receive address byte with ack (R3, R4, R5, R6)
      step("R3 write ack rx", 1, 8'h10, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      step("R6 rx addr byte", 0, 8'h00, 0, 1, 1, 0, 0, 0, 0, 0, 1);
      idle("R12 hold after rx", 1);
      // write same cycle as byte done keeps hold (R12)
      step("R12 wr with bd keeps", 1, 8'hFF, 0, 1, 0, 0, 0, 0, 0, 0, 1);
      step("R2 clear all", 1, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      // lost arb, no irq (R8); stop (R9); misplaced (R10)
      step("R8 arb lost", 0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      step("R9 stop", 0, 8'h00, 0, 0, 0, 0, 0, 1, 0, 0, 0);
      step("R10 misplaced irq R11", 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      step("R3 set tx ack", 1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R5 tx ack byte", 0, 8'h00, 0, 1, 1, 1, 0, 0, 0, 0, 0);
      step("R3 reset ack", 1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R7 start clears", 0, 8'h00, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R2 write1 keeps", 1, 8'hEB, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R10 clear berr", 1, 8'h7F, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R2 set beats clear", 1, 8'h00, 0, 0, 0, 0, 0, 1, 1, 0, 0);
      step("R3 start beats write", 1, 8'h04, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      step("R6 bd beats ack write", 1, 8'h10, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      idle("R11 irq level", 0);
      step("R11 clear bc", 1, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      idle("final", 0);
      wait (q.size() == 0);
      #2;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule